// File: doc/BRIEF.md
# SECDED-Protected Dual-Clock RAM

This block is a simple dual-port memory of 512 words, each holding 64 data bits and an 8-bit check byte. The write side and the read side run on clocks that are not related to each other. On every accepted write the block computes the check byte, stores it beside the data and shows it on a write-side output. On every accepted read the block decodes the stored word. It repairs a single flipped bit and raises a single-error flag. It raises a double-error flag when two bits have flipped.

The code is an extended Hamming (72,64) code. Seven Hamming check bits cover the data. An eighth bit makes the parity of the whole 72-bit word even. The parameter `OUT_REG` selects the read latency. With 0, the outputs change after the read clock edge that takes the request. With 1, an extra output register delays the data, the check byte and both flags by one more edge. A write-clocked test port can flip chosen stored bits so that the correction paths can be exercised.

Top module: `ecc_dual_ram`

## Requirements
- R1: On a `wr_clk` edge with `wr_en` high, the 64-bit `wr_data` and its check byte are stored at the word selected by the 9-bit `wr_addr`.
- R2: `wr_chk` shows the check byte of the word accepted at the most recent `wr_clk` edge with `wr_en` high. It holds its value while `wr_en` is low.
- R3: Check byte layout. Codeword positions 1 to 71 that are not powers of two carry data bits 0 to 63 in ascending order. Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Bit 7 makes the XOR of all 72 stored bits equal to zero.
- R4: With `OUT_REG`=0, `rd_data`, `rd_chk`, `rd_sbe` and `rd_dbe` show the word at `rd_addr` after the first `rd_clk` edge with `rd_en` high.
- R5: With `OUT_REG`=1, the same outputs change one `rd_clk` edge later, after the second edge. After the first edge they still hold their previous values.
- R6: A single flipped data bit is corrected on `rd_data`, and `rd_sbe` goes high with the same latency as the data.
- R7: A single flipped bit in the check byte, including bit 7, raises `rd_sbe` and leaves `rd_data` equal to the stored data.
- R8: Two flipped bits raise `rd_dbe` with `rd_sbe` low. `rd_data` then carries the stored data without correction. The two flags are never high together.
- R9: When `rd_en` is low, all read outputs keep their values.
- R10: On a `wr_clk` edge with `tst_flip_en` high, `tst_flip_mask` is XORed into the stored word at `tst_flip_addr`. Mask bits [63:0] map to the data, bits [70:64] to check bits 0 to 6, and bit 71 to check bit 7. A write to the same address on the same edge takes priority, and the flip is dropped.
- R11: After reset, `wr_chk`, `rd_data` and `rd_chk` are zero, and both flags are low.
- R12: `rd_chk` shows the stored check byte exactly as read, with no correction applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 64 | Data to store |
| wr_chk | output | 8 | Check byte of the last accepted write |
| tst_flip_en | input | 1 | Test flip request (write clock) |
| tst_flip_addr | input | 9 | Address of the word to corrupt |
| tst_flip_mask | input | 72 | Bits to invert in the stored word |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 64 | Corrected read data |
| rd_chk | output | 8 | Stored check byte as read |
| rd_sbe | output | 1 | Single-bit error found and corrected |
| rd_dbe | output | 1 | Uncorrectable double-bit error found |

## Verification
A normal write and a test flip can land on the same `wr_clk` edge and target the same word. The bench provokes this by raising `wr_en` and `tst_flip_en` together at one address, with a two-bit mask. It then reads the word back. If the flip had been applied, the read would show a double error. The expected result is instead clean new data, with both flags low and a check byte that matches the bench's own encoding. Each read is also observed on both latency variants in the same run. This shows whether the flags move together with the data at both depths.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int POS_MAX = DATA_W + HAM_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic              sbe;
        logic              dbe;
    } rd_out_t;

    // Hamming check bits over the data, data bits placed at non-power-of-two positions
    function automatic logic [HAM_W-1:0] ecc_hamming(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= POS_MAX; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int k = 0; k < HAM_W; k++) begin
                    if (p[k]) c[k] = c[k] ^ d[j];
                end
                j++;
            end
        end
        return c;
    endfunction

    // Data bit to invert for a given syndrome (zero if it names a check bit)
    function automatic logic [DATA_W-1:0] ecc_fix_mask(input logic [HAM_W-1:0] syn);
        logic [DATA_W-1:0] m;
        int j;
        m = '0;
        j = 0;
        for (int p = 1; p <= POS_MAX; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (syn == p[HAM_W-1:0]) m[j] = 1'b1;
                j++;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_ram_encoder.sv
module ecc_ram_encoder
    import ecc_ram_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [HAM_W-1:0] ham;

    always_comb begin
        ham = ecc_hamming(data);
        chk = {(^data) ^ (^ham), ham};
    end
endmodule

// File: rtl/ecc_ram_decoder.sv
module ecc_ram_decoder
    import ecc_ram_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output rd_out_t           dec
);
    logic [HAM_W-1:0]  syn;
    logic              odd;
    logic [DATA_W-1:0] raw;

    always_comb begin
        raw = word[DATA_W-1:0];
        syn = word[DATA_W +: HAM_W] ^ ecc_hamming(raw);
        odd = ^word;
        dec.chk = word[WORD_W-1:DATA_W];
        dec.sbe = odd;
        dec.dbe = !odd && (syn != '0);
        dec.data = odd ? (raw ^ ecc_fix_mask(syn)) : raw;
    end
endmodule

// File: rtl/ecc_ram_store.sv
module ecc_ram_store
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [WORD_W-1:0] flip_mask,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              flip_ok;
    logic [WORD_W-1:0] word_d, word_q;

    assign flip_ok = flip_en && !(wr_en && (wr_addr == flip_addr));

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
        if (flip_ok) mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
    end

    always_comb begin
        word_d = word_q;
        if (rd_en) word_d = mem[rd_addr];
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) word_q <= '0;
        else           word_q <= word_d;
    end

    assign rd_word = word_q;
endmodule

// File: rtl/ecc_dual_ram.sv
module ecc_dual_ram
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter bit OUT_REG = 1'b0
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    output logic [7:0]        wr_chk,
    input  logic              tst_flip_en,
    input  logic [ADDR_W-1:0] tst_flip_addr,
    input  logic [71:0]       tst_flip_mask,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output logic [7:0]        rd_chk,
    output logic              rd_sbe,
    output logic              rd_dbe
);
    logic [CHK_W-1:0]  enc_chk;
    logic [WORD_W-1:0] raw_word;
    rd_out_t           dec;
    rd_out_t           out_sel;
    logic [CHK_W-1:0]  wchk_d, wchk_q;

    ecc_ram_encoder u_enc (.data(wr_data), .chk(enc_chk));

    // write side: hold the last generated check byte
    always_comb begin
        wchk_d = wchk_q;
        if (wr_en) wchk_d = enc_chk;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) wchk_q <= '0;
        else           wchk_q <= wchk_d;
    end

    assign wr_chk = wchk_q;

    ecc_ram_store #(.ADDR_W(ADDR_W)) u_store (
        .wr_clk   (wr_clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  ({enc_chk, wr_data}),
        .flip_en  (tst_flip_en),
        .flip_addr(tst_flip_addr),
        .flip_mask(tst_flip_mask),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_word  (raw_word)
    );

    ecc_ram_decoder u_dec (.word(raw_word), .dec(dec));

    generate
        if (OUT_REG) begin : g_out_reg
            typedef struct packed {
                logic    load;
                rd_out_t out;
            } pipe_t;
            pipe_t pipe_d, pipe_q;

            always_comb begin
                pipe_d      = pipe_q;
                pipe_d.load = rd_en;
                if (pipe_q.load) pipe_d.out = dec;
            end

            always_ff @(posedge rd_clk or negedge rd_rst_n) begin
                if (!rd_rst_n) pipe_q <= '0;
                else           pipe_q <= pipe_d;
            end

            assign out_sel = pipe_q.out;
        end else begin : g_out_direct
            assign out_sel = dec;
        end
    endgenerate

    assign rd_data = out_sel.data;
    assign rd_chk  = out_sel.chk;
    assign rd_sbe  = out_sel.sbe;
    assign rd_dbe  = out_sel.dbe;
endmodule

// File: rtl/ecc_dual_ram_chk.sv
module ecc_dual_ram_chk #(
    parameter bit OUT_REG = 1'b0
) (
    input logic        wr_clk,
    input logic        wr_rst_n,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic [7:0]  wr_chk,
    input logic        rd_clk,
    input logic        rd_rst_n,
    input logic        rd_en,
    input logic [63:0] rd_data,
    input logic        rd_sbe,
    input logic        rd_dbe
);
    // R3
    wr_even_parity_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $past(wr_en) |-> ((^{$past(wr_data), wr_chk}) == 1'b0));

    // R2
    wr_chk_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !$past(wr_en) |-> $stable(wr_chk));

    // R8
    flags_exclusive_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $onehot0({rd_sbe, rd_dbe}));

    generate
        if (OUT_REG) begin : g_hold_reg
            // R9
            rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
                !$past(rd_en, 2) |-> ($stable(rd_data) && $stable(rd_sbe) && $stable(rd_dbe)));
        end else begin : g_hold_direct
            // R9
            rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
                !$past(rd_en) |-> ($stable(rd_data) && $stable(rd_sbe) && $stable(rd_dbe)));
        end
    endgenerate
endmodule

bind ecc_dual_ram ecc_dual_ram_chk #(.OUT_REG(OUT_REG)) u_chk (
    .wr_clk  (wr_clk),
    .wr_rst_n(wr_rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_chk  (wr_chk),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rd_sbe  (rd_sbe),
    .rd_dbe  (rd_dbe)
);

// File: tb/ecc_dual_ram_test.sv
module ecc_dual_ram_test;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;

    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_rst_n = 0, rd_rst_n = 0;
    logic        wr_en = 0, rd_en = 0, tst_flip_en = 0;
    logic [8:0]  wr_addr = '0, rd_addr = '0, tst_flip_addr = '0;
    logic [63:0] wr_data = '0;
    logic [71:0] tst_flip_mask = '0;
    logic [7:0]  wr_chk, rd_chk, rd_chk_r;
    logic [63:0] rd_data, rd_data_r;
    logic        rd_sbe, rd_dbe, rd_sbe_r, rd_dbe_r;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [79:0] prev_r;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    ecc_dual_ram #(.OUT_REG(1'b0)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_chk(wr_chk), .tst_flip_en(tst_flip_en),
        .tst_flip_addr(tst_flip_addr), .tst_flip_mask(tst_flip_mask),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_chk(rd_chk), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe));

    ecc_dual_ram #(.OUT_REG(1'b1)) uut_r (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_chk(), .tst_flip_en(tst_flip_en),
        .tst_flip_addr(tst_flip_addr), .tst_flip_mask(tst_flip_mask),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_r), .rd_chk(rd_chk_r), .rd_sbe(rd_sbe_r), .rd_dbe(rd_dbe_r));

    // position in the codeword of data bit j
    function automatic int tb_pos(input int j);
        int p = 0;
        int n = -1;
        while (n < j) begin
            p++;
            if ((p & (p - 1)) != 0) n++;
        end
        return p;
    endfunction

    function automatic logic [7:0] tb_code(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int j = 0; j < 64; j++) begin
            int p = tb_pos(j);
            for (int k = 0; k < 7; k++) if (p[k]) c[k] ^= d[j];
        end
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] a, input logic [63:0] d);
        @(negedge wr_clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
        check("R2 R3 wr_chk", {72'd0, wr_chk}, {72'd0, tb_code(d)});
        wr_data = ~d;
        @(negedge wr_clk);
        check("R2 wr_chk hold", {72'd0, wr_chk}, {72'd0, tb_code(d)});
    endtask

    task automatic do_flip(input logic [8:0] a, input logic [71:0] m);
        @(negedge wr_clk);
        tst_flip_en = 1; tst_flip_addr = a; tst_flip_mask = m;
        @(negedge wr_clk);
        tst_flip_en = 0;
        @(negedge wr_clk);
    endtask

    // exp = {sbe, dbe, chk, data}; checks both latency variants and holding
    task automatic do_read(input string tag, input logic [8:0] a, input logic [79:0] exp);
        repeat (2) @(negedge rd_clk);
        rd_en = 1; rd_addr = a;
        @(negedge rd_clk);
        rd_en = 0; rd_addr = ~a;
        check({tag, " R4 direct"}, {6'd0, rd_sbe, rd_dbe, rd_chk, rd_data}, exp);
        check({tag, " R5 reg early"}, {6'd0, rd_sbe_r, rd_dbe_r, rd_chk_r, rd_data_r}, prev_r);
        @(negedge rd_clk);
        check({tag, " R5 reg"}, {6'd0, rd_sbe_r, rd_dbe_r, rd_chk_r, rd_data_r}, exp);
        check({tag, " R9 direct hold"}, {6'd0, rd_sbe, rd_dbe, rd_chk, rd_data}, exp);
        @(negedge rd_clk);
        check({tag, " R9 reg hold"}, {6'd0, rd_sbe_r, rd_dbe_r, rd_chk_r, rd_data_r}, exp);
        prev_r = exp;
    endtask

    function automatic logic [79:0] ex(input logic s, input logic db, input logic [7:0] c,
                                       input logic [63:0] d);
        return {6'd0, s, db, c, d};
    endfunction

    task automatic t_reset();
        check("R11 wr_chk", {72'd0, wr_chk}, 80'd0);
        check("R11 rd direct", {6'd0, rd_sbe, rd_dbe, rd_chk, rd_data}, 80'd0);
        check("R11 rd reg", {6'd0, rd_sbe_r, rd_dbe_r, rd_chk_r, rd_data_r}, 80'd0);
        prev_r = '0;
    endtask

    task automatic t_patterns();
        logic [63:0] pats [5];
        pats[0] = 64'h0;
        pats[1] = '1;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'h8000_0000_0000_0001;
        pats[4] = 64'hA5A5_5A5A_F00F_0FF0;
        for (int i = 0; i < 5; i++) do_write(9'(i * 97 + 3), pats[i]);
        for (int i = 0; i < 5; i++)
            do_read("R1 R12 clean", 9'(i * 97 + 3), ex(0, 0, tb_code(pats[i]), pats[i]));
        do_write(9'h1FF, 64'hDEAD_BEEF_0BAD_F00D);
        do_read("R1 top addr", 9'h1FF, ex(0, 0, tb_code(64'hDEAD_BEEF_0BAD_F00D), 64'hDEAD_BEEF_0BAD_F00D));
    endtask

    task automatic t_single_data();
        logic [63:0] d = 64'h1357_9BDF_2468_ACE0;
        for (int b = 0; b < 64; b += 21) begin
            do_write(9'd40, d);
            do_flip(9'd40, 72'd1 << b);
            do_read("R6 data bit", 9'd40, ex(1, 0, tb_code(d), d));
        end
    endtask

    task automatic t_single_chk();
        logic [63:0] d = 64'hFEDC_BA98_7654_3210;
        logic [7:0]  c = tb_code(d);
        do_write(9'd77, d);
        do_flip(9'd77, 72'd1 << 67);
        do_read("R7 R12 check bit", 9'd77, ex(1, 0, c ^ 8'h08, d));
        do_write(9'd77, d);
        do_flip(9'd77, 72'd1 << 71);
        do_read("R7 overall bit", 9'd77, ex(1, 0, c ^ 8'h80, d));
    endtask

    task automatic t_double();
        logic [63:0] d = 64'h0F0F_1234_5678_F0F0;
        do_write(9'd200, d);
        do_flip(9'd200, (72'd1 << 5) | (72'd1 << 44));
        do_read("R8 two data bits", 9'd200, ex(0, 1, tb_code(d), d ^ 64'h0000_1000_0000_0020));
        do_write(9'd201, d);
        do_flip(9'd201, (72'd1 << 9) | (72'd1 << 65));
        do_read("R8 data and check", 9'd201, ex(0, 1, tb_code(d) ^ 8'h02, d ^ 64'h200));
    endtask

    task automatic t_write_vs_flip();
        logic [63:0] d1 = 64'h1111_2222_3333_4444;
        logic [63:0] d2 = 64'h5555_6666_7777_8888;
        do_write(9'd300, d1);
        @(negedge wr_clk);
        wr_en = 1; wr_addr = 9'd300; wr_data = d2;
        tst_flip_en = 1; tst_flip_addr = 9'd300; tst_flip_mask = 72'h3;
        @(negedge wr_clk);
        wr_en = 0; tst_flip_en = 0;
        check("R10 R2 wr_chk", {72'd0, wr_chk}, {72'd0, tb_code(d2)});
        do_read("R10 write wins", 9'd300, ex(0, 0, tb_code(d2), d2));
        do_flip(9'd300, 72'h3);
        do_read("R10 flip applied", 9'd300, ex(0, 1, tb_code(d2), d2 ^ 64'h3));
    endtask

    initial begin
        #(RD_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge rd_clk);
        t_reset();
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge rd_clk);
        t_reset();
        t_patterns();
        t_single_data();
        t_single_chk();
        t_double();
        t_write_vs_flip();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule